// File: doc/BRIEF.md
# Indexed Register Port to Byte Memory Bridge

This block connects an 8/16-bit host bus to an internal byte-addressed memory that the host cannot address directly. The host sees only two locations, chosen by one address line: with that line low, a write picks a register number; with it high, a cycle reads or writes whatever was picked. Three pointer registers together form a 17-bit byte address into the memory.

Picking one particular register number, with no data cycle after it, turns every later data cycle into a memory access at the pointer. After each such access the pointer moves forward by the access size. Two byte enables choose between byte and word transfers. A mode input swaps the byte lanes for big-endian hosts. Picking any other register number leaves this streaming mode, so the pointer can be reloaded and streaming started again at a new address.

Each clock edge at which chip select is high is one host cycle. Read data is registered and appears one cycle after the qualifying edge. It holds until the next read.

Top module: `hmb_bridge`

## Requirements
- R1: After reset the pointer is 0x00000, streaming mode is off, the selected register number is 0x00 and `rdata` is 0x0000.
- R2: A cycle with `cs`=1, `a0`=0, `wr`=1 latches `wdata[7:0]` as the selected register number. A cycle with `cs`=1, `a0`=0, `wr`=0 returns 0x0000 on `rdata`.
- R3: Outside streaming mode, a word data write (both enables) stores the even-lane byte in the selected register and the odd-lane byte in the register numbered one higher. A byte data write stores the enabled lane's byte in the selected register only. Register 0xC0 holds pointer bits [7:0] and 0xC1 holds bits [15:8]. Reads return the same bytes on the same lanes.
- R4: Register 0xC2 bit 0 holds pointer bit 16. Its other bits ignore writes and read as zero.
- R5: Outside streaming mode, registers other than 0xC0, 0xC1 and 0xC2 ignore writes and read as zero.
- R6: A command write of 0xC4 turns streaming mode on without any data cycle. The very next data cycle accesses memory at the pointer.
- R7: In streaming mode a word access uses the pointer with bit 0 cleared and moves the even byte and the odd byte together. The pointer then becomes that even address plus 2. Memory holds 2^(RAM_AW+1) bytes, indexed by pointer bits [RAM_AW:0].
- R8: In streaming mode a byte access (exactly one enable) uses the pointer address, even or odd, and moves the byte on the enabled lane. The pointer then advances by 1. A byte read returns zero on the other lane.
- R9: With `big_endian`=0 the even-address byte travels on `[7:0]`; with `big_endian`=1 it travels on `[15:8]`. This applies to memory and to register word transfers.
- R10: A command write of any number other than 0xC4 turns streaming mode off, and later data cycles reach registers again. A pointer rewritten through 0xC0 to 0xC2 is the address used once 0xC4 is written again.
- R11: The pointer wraps from 0x1FFFF to 0x00000 when it advances.
- R12: Read data appears on `rdata` one cycle after the qualifying edge and holds until the next read cycle.
- R13: A data cycle with neither byte enable makes no access: memory, registers, pointer and `rdata` are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs | input | 1 | Chip select; high qualifies one host cycle per edge |
| a0 | input | 1 | 0 = command cycle, 1 = data cycle |
| wr | input | 1 | 1 = write, 0 = read |
| be_lo | input | 1 | Enable for lane [7:0] |
| be_hi | input | 1 | Enable for lane [15:8] |
| big_endian | input | 1 | Swaps the lane carrying the even byte |
| wdata | input | 16 | Host write data |
| rdata | output | 16 | Registered host read data |

## Verification
Assertions check on every cycle that the 0xC4 command arms streaming and any other command ends it. They also check that a byte step adds exactly one to the pointer, that a word step leaves it even, and that the pointer and `rdata` stay still when no qualifying cycle occurs. Lane placement under both endian modes, the pairing of 0xC0 and 0xC1 in one word write, memory contents after streaming, the 17-bit wrap and reload-then-restart can only be shown by the bench's scenarios. Those scenarios compare every read against a byte-level reference model.

// File: rtl/hmb_pkg.sv
package hmb_pkg;

   localparam logic [7:0] IDX_PTR_B0 = 8'hC0;
   localparam logic [7:0] IDX_PTR_B1 = 8'hC1;
   localparam logic [7:0] IDX_PTR_B2 = 8'hC2;
   localparam logic [7:0] IDX_STREAM = 8'hC4;

   // Width of the padded pointer view used by the register decode
   localparam int PAD_W = 24;

   // Byte seen by the host for register idx, given the padded pointer
   function automatic logic [7:0] reg_view(input logic [7:0] idx,
                                           input logic [PAD_W-1:0] p);
      logic [7:0] v;
      case (idx)
         IDX_PTR_B0: v = p[7:0];
         IDX_PTR_B1: v = p[15:8];
         IDX_PTR_B2: v = p[23:16];
         default:    v = 8'h00;
      endcase
      return v;
   endfunction

   // Padded pointer after one byte written to register idx
   function automatic logic [PAD_W-1:0] reg_put(input logic [PAD_W-1:0] p,
                                                input logic [7:0] idx,
                                                input logic [7:0] d);
      logic [PAD_W-1:0] q;
      q = p;
      case (idx)
         IDX_PTR_B0: q[7:0]   = d;
         IDX_PTR_B1: q[15:8]  = d;
         IDX_PTR_B2: q[23:16] = d;
         default:    q = p;
      endcase
      return q;
   endfunction

endpackage

// File: rtl/hmb_lane_swap.sv
module hmb_lane_swap #(
   parameter int LANE_W     = 8,
   parameter bit ALLOW_SWAP = 1'b1
) (
   input  logic              swap,
   input  logic [LANE_W-1:0] in_lo,
   input  logic [LANE_W-1:0] in_hi,
   output logic [LANE_W-1:0] out_lo,
   output logic [LANE_W-1:0] out_hi
);

   generate
      if (ALLOW_SWAP) begin : g_swap
         assign out_lo = swap ? in_hi : in_lo;
         assign out_hi = swap ? in_lo : in_hi;
      end else begin : g_fixed
         logic unused_swap;
         assign unused_swap = swap;
         assign out_lo = in_lo;
         assign out_hi = in_hi;
      end
   endgenerate

endmodule

// File: rtl/hmb_ptr_regs.sv
module hmb_ptr_regs
   import hmb_pkg::*;
#(
   parameter int PTR_W = 17
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wa_en,
   input  logic [7:0]       wa_idx,
   input  logic [7:0]       wa_d,
   input  logic             wb_en,
   input  logic [7:0]       wb_idx,
   input  logic [7:0]       wb_d,
   input  logic             step_byte,
   input  logic             step_word,
   output logic [PTR_W-1:0] ptr
);

   localparam int PADW = PAD_W;

   logic [PADW-1:0]  pad_cur;
   logic [PADW-1:0]  pad_a;
   logic [PADW-1:0]  pad_b;
   logic [PTR_W-1:0] ptr_loaded;
   logic [PTR_W-1:0] ptr_even;

   always_comb begin
      pad_cur = PADW'(ptr);
      pad_a   = wa_en ? reg_put(pad_cur, wa_idx, wa_d) : pad_cur;
      pad_b   = wb_en ? reg_put(pad_a, wb_idx, wb_d) : pad_a;
   end

   assign ptr_loaded = pad_b[PTR_W-1:0];
   assign ptr_even   = {ptr[PTR_W-1:1], 1'b0};

   generate
      if (PTR_W < PADW) begin : g_pad_unused
         logic unused_pad;
         assign unused_pad = ^pad_b[PADW-1:PTR_W];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr <= '0;
      end else if (step_word) begin
         ptr <= ptr_even + PTR_W'(2);
      end else if (step_byte) begin
         ptr <= ptr + PTR_W'(1);
      end else begin
         ptr <= ptr_loaded;
      end
   end

   assert_byte_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (step_byte && !step_word) |=> ptr == PTR_W'($past(ptr) + PTR_W'(1)));

   assert_word_even_R7: assert property (@(posedge clk) disable iff (!rst_n)
      step_word |=> !ptr[0]);

   assert_ptr_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
      !(wa_en || wb_en || step_byte || step_word) |=> $stable(ptr));

endmodule

// File: rtl/hmb_byte_ram.sv
module hmb_byte_ram #(
   parameter int AW = 10
) (
   input  logic          clk,
   input  logic [AW-1:0] row,
   input  logic [1:0]    we,
   input  logic [15:0]   wd,
   output logic [15:0]   rd
);

   localparam int ROWS = 1 << AW;

   // Bank 0 holds even addresses, bank 1 holds odd addresses
   generate
      for (genvar g = 0; g < 2; g++) begin : g_bank
         logic [7:0] cells [ROWS];
         always_ff @(posedge clk) begin
            if (we[g]) begin
               cells[row] <= wd[8*g +: 8];
            end
         end
         assign rd[8*g +: 8] = cells[row];
      end
   endgenerate

endmodule

// File: rtl/hmb_bridge.sv
module hmb_bridge
   import hmb_pkg::*;
#(
   parameter int PTR_W      = 17,
   parameter int RAM_AW     = 10,
   parameter bit ALLOW_SWAP = 1'b1
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        cs,
   input  logic        a0,
   input  logic        wr,
   input  logic        be_lo,
   input  logic        be_hi,
   input  logic        big_endian,
   input  logic [15:0] wdata,
   output logic [15:0] rdata
);

   localparam int PADW = PAD_W;

   generate
      if (PTR_W < 17 || PTR_W > PADW) begin : g_bad_ptr
         $error("hmb_bridge: PTR_W must lie in 17..24");
      end
      if (RAM_AW < 1 || RAM_AW + 1 > PTR_W) begin : g_bad_ram
         $error("hmb_bridge: RAM_AW+1 must not exceed PTR_W");
      end
   endgenerate

   // Cycle decode
   logic any_en, word_acc, cmd_wr, cmd_rd, dat_cyc, mem_cyc, reg_cyc;
   logic stream_on;
   logic [7:0] sel_idx;
   logic [7:0] sel_nxt;

   assign any_en   = be_lo | be_hi;
   assign word_acc = be_lo & be_hi;
   assign cmd_wr   = cs & ~a0 & wr;
   assign cmd_rd   = cs & ~a0 & ~wr;
   assign dat_cyc  = cs & a0 & any_en;
   assign mem_cyc  = dat_cyc & stream_on;
   assign reg_cyc  = dat_cyc & ~stream_on;
   assign sel_nxt  = sel_idx + 8'd1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_idx   <= 8'h00;
         stream_on <= 1'b0;
      end else if (cmd_wr) begin
         sel_idx   <= wdata[7:0];
         stream_on <= (wdata[7:0] == IDX_STREAM);
      end
   end

   // Write lanes to even/odd bytes
   logic [7:0] w_even, w_odd, w_byte;

   hmb_lane_swap #(.LANE_W(8), .ALLOW_SWAP(ALLOW_SWAP)) u_wswap (
      .swap   (big_endian),
      .in_lo  (wdata[7:0]),
      .in_hi  (wdata[15:8]),
      .out_lo (w_even),
      .out_hi (w_odd)
   );

   assign w_byte = be_lo ? wdata[7:0] : wdata[15:8];

   // Pointer and register file
   logic [PTR_W-1:0] ptr;
   logic             wa_en, wb_en;
   logic [7:0]       wa_d;

   assign wa_en = reg_cyc & wr;
   assign wb_en = reg_cyc & wr & word_acc;
   assign wa_d  = word_acc ? w_even : w_byte;

   hmb_ptr_regs #(.PTR_W(PTR_W)) u_ptr (
      .clk       (clk),
      .rst_n     (rst_n),
      .wa_en     (wa_en),
      .wa_idx    (sel_idx),
      .wa_d      (wa_d),
      .wb_en     (wb_en),
      .wb_idx    (sel_nxt),
      .wb_d      (w_odd),
      .step_byte (mem_cyc & ~word_acc),
      .step_word (mem_cyc & word_acc),
      .ptr       (ptr)
   );

   // Memory
   logic [RAM_AW-1:0] row;
   logic [1:0]        ram_we;
   logic [15:0]       ram_wd, ram_rd;
   logic              odd_sel;

   assign row     = ptr[RAM_AW:1];
   assign odd_sel = ptr[0];

   always_comb begin
      ram_we = 2'b00;
      ram_wd = {w_odd, w_even};
      if (mem_cyc && wr) begin
         if (word_acc) begin
            ram_we = 2'b11;
         end else begin
            ram_we = odd_sel ? 2'b10 : 2'b01;
            ram_wd = {w_byte, w_byte};
         end
      end
   end

   hmb_byte_ram #(.AW(RAM_AW)) u_ram (
      .clk (clk),
      .row (row),
      .we  (ram_we),
      .wd  (ram_wd),
      .rd  (ram_rd)
   );

   // Read data
   logic [PADW-1:0] ptr_pad;
   logic [7:0]      r_even, r_odd, r_byte, r_lo, r_hi;
   logic [15:0]     rd_val;

   assign ptr_pad = PADW'(ptr);

   always_comb begin
      if (stream_on) begin
         r_even = ram_rd[7:0];
         r_odd  = ram_rd[15:8];
         r_byte = odd_sel ? ram_rd[15:8] : ram_rd[7:0];
      end else begin
         r_even = reg_view(sel_idx, ptr_pad);
         r_odd  = reg_view(sel_nxt, ptr_pad);
         r_byte = r_even;
      end
   end

   hmb_lane_swap #(.LANE_W(8), .ALLOW_SWAP(ALLOW_SWAP)) u_rswap (
      .swap   (big_endian),
      .in_lo  (r_even),
      .in_hi  (r_odd),
      .out_lo (r_lo),
      .out_hi (r_hi)
   );

   always_comb begin
      if (word_acc) begin
         rd_val = {r_hi, r_lo};
      end else if (be_lo) begin
         rd_val = {8'h00, r_byte};
      end else begin
         rd_val = {r_byte, 8'h00};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata <= 16'h0000;
      end else if (cmd_rd) begin
         rdata <= 16'h0000;
      end else if (dat_cyc && !wr) begin
         rdata <= rd_val;
      end
   end

   assert_stream_arm_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && wdata[7:0] == IDX_STREAM) |=> stream_on);

   assert_stream_exit_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_wr && wdata[7:0] != IDX_STREAM) |=> !stream_on);

   assert_rdata_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !(cs && !wr && (!a0 || any_en)) |=> $stable(rdata));

   assert_cmd_read_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_rd |=> rdata == 16'h0000);

endmodule

// File: tb/hmb_bridge_test.sv
module hmb_bridge_test;

   localparam int RAM_AW = 10;
   localparam int NBYTES = 1 << (RAM_AW + 1);

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cs = 1'b0, a0 = 1'b0, wr = 1'b0, be_lo = 1'b0, be_hi = 1'b0;
   logic        big_endian = 1'b0;
   logic [15:0] wdata = 16'h0000;
   logic [15:0] rdata;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   hmb_bridge #(.PTR_W(17), .RAM_AW(RAM_AW)) uut (
      .clk(clk), .rst_n(rst_n), .cs(cs), .a0(a0), .wr(wr),
      .be_lo(be_lo), .be_hi(be_hi), .big_endian(big_endian),
      .wdata(wdata), .rdata(rdata)
   );

   always #4 clk = ~clk;

   // Reference model
   logic [16:0] m_ptr;
   bit          m_stream;
   logic [7:0]  m_sel;
   logic [7:0]  m_mem [NBYTES];

   function automatic logic [7:0] m_reg(input logic [7:0] idx);
      case (idx)
         8'hC0:   return m_ptr[7:0];
         8'hC1:   return m_ptr[15:8];
         8'hC2:   return {7'b0, m_ptr[16]};
         default: return 8'h00;
      endcase
   endfunction

   task automatic m_put(input logic [7:0] idx, input logic [7:0] d);
      case (idx)
         8'hC0:   m_ptr[7:0]  = d;
         8'hC1:   m_ptr[15:8] = d;
         8'hC2:   m_ptr[16]   = d[0];
         default: ;
      endcase
   endtask

   task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // One host cycle; called at a falling edge, returns at the next falling edge
   task automatic op(input bit a, input bit w, input bit bl, input bit bh,
                     input logic [15:0] d, input string tag);
      logic [15:0] exp;
      bit          chk;
      logic [16:0] ea;
      logic [7:0]  e, o, b;
      exp = 16'h0000;
      chk = 1'b0;
      if (!a) begin
         if (w) begin
            m_sel    = d[7:0];
            m_stream = (d[7:0] == 8'hC4);
         end else begin
            chk = 1'b1;
         end
      end else if (bl || bh) begin
         if (m_stream) begin
            if (bl && bh) begin
               ea = {m_ptr[16:1], 1'b0};
               if (w) begin
                  m_mem[ea[RAM_AW:0]]         = big_endian ? d[15:8] : d[7:0];
                  m_mem[ea[RAM_AW:0] | 11'd1] = big_endian ? d[7:0] : d[15:8];
               end else begin
                  e = m_mem[ea[RAM_AW:0]];
                  o = m_mem[ea[RAM_AW:0] | 11'd1];
                  exp = big_endian ? {e, o} : {o, e};
                  chk = 1'b1;
               end
               m_ptr = ea + 17'd2;
            end else begin
               if (w) begin
                  m_mem[m_ptr[RAM_AW:0]] = bl ? d[7:0] : d[15:8];
               end else begin
                  b = m_mem[m_ptr[RAM_AW:0]];
                  exp = bl ? {8'h00, b} : {b, 8'h00};
                  chk = 1'b1;
               end
               m_ptr = m_ptr + 17'd1;
            end
         end else begin
            if (bl && bh) begin
               if (w) begin
                  e = big_endian ? d[15:8] : d[7:0];
                  o = big_endian ? d[7:0] : d[15:8];
                  m_put(m_sel, e);
                  m_put(m_sel + 8'd1, o);
               end else begin
                  e = m_reg(m_sel);
                  o = m_reg(m_sel + 8'd1);
                  exp = big_endian ? {e, o} : {o, e};
                  chk = 1'b1;
               end
            end else begin
               if (w) begin
                  m_put(m_sel, bl ? d[7:0] : d[15:8]);
               end else begin
                  b = m_reg(m_sel);
                  exp = bl ? {8'h00, b} : {b, 8'h00};
                  chk = 1'b1;
               end
            end
         end
      end
      cs = 1'b1; a0 = a; wr = w; be_lo = bl; be_hi = bh; wdata = d;
      @(posedge clk);
      @(negedge clk);
      cs = 1'b0;
      if (chk) check(rdata, exp, tag);
   endtask

   task automatic cmd(input logic [7:0] idx);
      op(1'b0, 1'b1, 1'b0, 1'b0, {8'h00, idx}, "cmd");
   endtask

   task automatic set_ptr(input logic [16:0] p);
      cmd(8'hC0);
      op(1'b1, 1'b1, 1'b1, 1'b1, big_endian ? {p[7:0], p[15:8]} : p[15:0], "R3 load");
      cmd(8'hC2);
      op(1'b1, 1'b1, 1'b1, 1'b0, {15'h0, p[16]}, "R4 load");
   endtask

   initial begin
      logic [15:0] held;
      void'($urandom(32'd20240611));
      m_ptr = '0; m_stream = 1'b0; m_sel = 8'h00;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state seen at the ports
      check(rdata, 16'h0000, "R1 rdata after reset");
      op(1'b1, 1'b0, 1'b1, 1'b1, 16'h0, "R1 reg sel 0 reads zero");
      cmd(8'hC0);
      op(1'b1, 1'b0, 1'b1, 1'b1, 16'h0, "R1 pointer low word zero");
      cmd(8'hC2);
      op(1'b1, 1'b0, 1'b1, 1'b0, 16'h0, "R1 pointer bit16 zero");

      // R2: command read returns zero
      op(1'b0, 1'b0, 1'b1, 1'b1, 16'h0, "R2 command read");

      // R3: word write pairs C0/C1, byte write touches one register
      cmd(8'hC0);
      op(1'b1, 1'b1, 1'b1, 1'b1, 16'h3412, "R3 word write");
      op(1'b1, 1'b0, 1'b1, 1'b1, 16'h0, "R3 word read C0/C1");
      check(rdata, 16'h3412, "R3 C0=12 C1=34");
      cmd(8'hC1);
      op(1'b1, 1'b1, 1'b0, 1'b1, 16'h5600, "R3 byte write C1");
      op(1'b1, 1'b0, 1'b1, 1'b0, 16'h0, "R3 byte read C1 low lane");
      check(rdata, 16'h0056, "R3 C1 byte value");

      // R4: only bit 0 of C2 is kept
      cmd(8'hC2);
      op(1'b1, 1'b1, 1'b1, 1'b0, 16'h00FF, "R4 write C2");
      op(1'b1, 1'b0, 1'b1, 1'b0, 16'h0, "R4 read C2");
      check(rdata, 16'h0001, "R4 C2 keeps bit 0 only");

      // R5: unimplemented register ignores writes and reads zero
      cmd(8'h55);
      op(1'b1, 1'b1, 1'b1, 1'b1, 16'hA5A5, "R5 write unimplemented");
      op(1'b1, 1'b0, 1'b1, 1'b1, 16'h0, "R5 read unimplemented");
      check(rdata, 16'h0000, "R5 reads zero");

      // R6/R7: fill memory with word streaming from address 0
      set_ptr(17'h0);
      cmd(8'hC4);
      for (int i = 0; i < NBYTES / 2; i++) begin
         op(1'b1, 1'b1, 1'b1, 1'b1, 16'(i * 16'h0101 + 16'h3C5A), "R6 fill");
      end
      cmd(8'hC0);
      op(1'b1, 1'b0, 1'b1, 1'b1, 16'h0, "R7 pointer after fill");
      check(rdata, 16'(NBYTES), "R7 pointer advanced by 2 per word");

      // R7: word access from odd pointer uses the even address
      set_ptr(17'h00011);
      cmd(8'hC4);
      op(1'b1, 1'b0, 1'b1, 1'b1, 16'h0, "R7 word read at odd pointer");
      cmd(8'hC0);
      op(1'b1, 1'b0, 1'b1, 1'b1, 16'h0, "R7 pointer became 0x12");
      check(rdata, 16'h0012, "R7 even plus 2");

      // R8: byte streaming on odd and even addresses
      set_ptr(17'h00101);
      cmd(8'hC4);
      op(1'b1, 1'b1, 1'b0, 1'b1, 16'h9900, "R8 byte write odd");
      op(1'b1, 1'b1, 1'b1, 1'b0, 16'h0077, "R8 byte write even");
      set_ptr(17'h00101);
      cmd(8'hC4);
      op(1'b1, 1'b0, 1'b1, 1'b0, 16'h0, "R8 byte read odd");
      check(rdata, 16'h0099, "R8 odd byte on low lane");
      op(1'b1, 1'b0, 1'b0, 1'b1, 16'h0, "R8 byte read even");
      check(rdata, 16'h7700, "R8 even byte on high lane");

      // R9: big-endian lane swap for memory and registers
      big_endian = 1'b1;
      set_ptr(17'h00200);
      cmd(8'hC4);
      op(1'b1, 1'b1, 1'b1, 1'b1, 16'hABCD, "R9 BE word write");
      big_endian = 1'b0;
      set_ptr(17'h00200);
      cmd(8'hC4);
      op(1'b1, 1'b0, 1'b1, 1'b1, 16'h0, "R9 LE read of BE data");
      check(rdata, 16'hCDAB, "R9 even byte AB on low lane in LE");
      big_endian = 1'b1;
      cmd(8'hC0);
      op(1'b1, 1'b0, 1'b1, 1'b1, 16'h0, "R9 BE register word read");
      check(rdata, 16'h0202, "R9 C0 on high lane");
      big_endian = 1'b0;

      // R10: leaving and re-entering streaming with a reloaded pointer
      set_ptr(17'h00100);
      cmd(8'hC4);
      op(1'b1, 1'b0, 1'b1, 1'b1, 16'h0, "R10 read at 0x100");
      cmd(8'hC1);
      op(1'b1, 1'b1, 1'b1, 1'b0, 16'h0003, "R10 reload C1");
      cmd(8'hC4);
      op(1'b1, 1'b0, 1'b1, 1'b1, 16'h0, "R10 read at reloaded 0x302");

      // R11: wrap at the top of the 17-bit space
      set_ptr(17'h1FFFF);
      cmd(8'hC4);
      op(1'b1, 1'b1, 1'b0, 1'b1, 16'hE100, "R11 byte write at 0x1FFFF");
      cmd(8'hC0);
      op(1'b1, 1'b0, 1'b1, 1'b1, 16'h0, "R11 pointer low after wrap");
      check(rdata, 16'h0000, "R11 low bits zero");
      cmd(8'hC2);
      op(1'b1, 1'b0, 1'b1, 1'b0, 16'h0, "R11 bit16 after wrap");
      check(rdata, 16'h0000, "R11 bit16 zero");

      // R12/R13: hold of rdata, no-enable cycles have no effect
      cmd(8'hC0);
      op(1'b1, 1'b0, 1'b1, 1'b1, 16'h0, "R12 read pointer");
      held = rdata;
      op(1'b1, 1'b1, 1'b1, 1'b1, 16'h7777, "R12 write between reads");
      check(rdata, held, "R12 rdata held across write");
      op(1'b1, 1'b1, 1'b0, 1'b0, 16'hFFFF, "R13 write no enables");
      op(1'b1, 1'b0, 1'b0, 1'b0, 16'h0, "R13 read no enables");
      check(rdata, held, "R13 rdata unchanged");
      op(1'b1, 1'b0, 1'b1, 1'b1, 16'h0, "R13 pointer after no-enable write");
      check(rdata, 16'h7777, "R13 register unchanged by no-enable cycle");
      cmd(8'hC4);
      op(1'b1, 1'b1, 1'b0, 1'b0, 16'h1234, "R13 stream no enables");
      cmd(8'hC0);
      op(1'b1, 1'b0, 1'b1, 1'b1, 16'h0, "R13 pointer not advanced");
      check(rdata, 16'h7777, "R13 pointer still 0x7777");

      // Random mix, every read checked against the model
      for (int n = 0; n < 3000; n++) begin
         int k;
         logic [15:0] d;
         k = int'($urandom_range(0, 99));
         d = 16'($urandom);
         if (k < 3) begin
            big_endian = ~big_endian;
         end else if (k < 15) begin
            case ($urandom_range(0, 5))
               0: cmd(8'hC0);
               1: cmd(8'hC1);
               2: cmd(8'hC2);
               3: cmd(8'h55);
               default: cmd(8'hC4);
            endcase
         end else if (k < 17) begin
            op(1'b0, 1'b0, 1'b1, 1'b1, d, "R2 random command read");
         end else begin
            logic [1:0] en;
            en = 2'($urandom);
            op(1'b1, 1'($urandom), en[0], en[1], d, "R7 R8 R9 random data");
         end
      end

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule